// File: doc/BRIEF.md
# Transmit descriptor ring reader

This block moves outgoing frames from shared memory to a MAC. The host builds a ring of four-word descriptors in memory. Each descriptor points at a frame buffer and carries a negated byte count. The host hands a descriptor to the engine by setting its ownership bit. After it has prepared one or more descriptors, the host pulses a transmit-demand input.

The engine walks the ring from its current index. For each descriptor it reads the flag word first, and it reads the address and length only once ownership is confirmed. It then fetches the buffer a 16-bit word at a time and offers the bytes on a ready/valid byte stream that marks the first and last byte. When the frame is done, the engine writes a status word and then the flag word with ownership handed back, pulses an interrupt, and moves to the next entry. The engine goes idle at the first entry the host still holds.

A collision input stands in for the MAC. Each pulse restarts the current frame from its first byte. At the sixteenth collision the engine abandons the frame and reports a retry failure.

Top module: `tx_ring_reader`

## Requirements
- R1: After reset the block issues no memory request, offers no byte (tx_valid low) and holds tx_int low until tx_demand is pulsed.
- R2: A tx_demand pulse starts a scan at the current ring index. The scan processes consecutive device-owned descriptors and stops at the first host-owned one, after which no memory request is made. Descriptors the host hands over while the block is idle are not touched until the next tx_demand pulse.
- R3: Descriptor n sits at word address ring_base + 4n. The block reads word 1 first: flag in bits 15:8 with ownership at bit 15 (1 = device), base-high byte in bits 7:0. Word 0 (base low) and word 2 (length) are read only after that flag read returned ownership set.
- R4: The byte count is the low 12 bits of the two's-complement negation of the length word (word 2, top nibble forced to 1 by the host). Exactly that many bytes are offered.
- R5: The buffer byte address is {base-high, base-low}. Memory is addressed in 16-bit words at byte address >> 1. The even byte of a word is bits 15:8 and the odd byte is bits 7:0, so a buffer may start at an odd byte.
- R6: tx_data is held stable while tx_valid is high and tx_ready is low. tx_sop marks the first byte of each attempt and tx_eop marks the last byte of a completed frame.
- R7: On completion the block writes the status word (word 3) before the flag word (word 1). In the written flag, bit 7 is cleared and bits 1:0 and the base-high byte are kept. tx_int is high for exactly one cycle, during the flag write.
- R8: A col_in pulse while a byte is offered drops that byte and restarts the frame at its first byte. A frame sent after exactly one collision sets flag bit 3. A frame sent after two or more collisions sets flag bit 4. Neither case sets error bit 6, and the status word is 0.
- R9: The sixteenth collision on one frame abandons it with no end-of-frame byte. The block then writes status bit 10 and flag bits 6 and 4, and advances the ring.
- R10: The ring holds 2^k descriptors, with k in bits 15:13 of ring_len. After entry 2^k - 1 the index wraps to 0, and memory past the ring end is never touched.
- R11: A byte count of zero offers no bytes and writes status bit 15 and flag bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_demand | input | 1 | One-cycle pulse that starts a ring scan |
| ring_base | input | AW | Word address of descriptor 0 |
| ring_len | input | 16 | Ring-length word; bits 15:13 hold log2 of the entry count |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read (read data returns next cycle) |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | tx_data is offered |
| tx_sop | output | 1 | First byte of an attempt |
| tx_eop | output | 1 | Last byte of the frame |
| tx_ready | input | 1 | Sink takes the byte this cycle |
| col_in | input | 1 | Collision indication from the MAC |
| tx_int | output | 1 | One-cycle completion pulse |

## Verification
The retry-failure path is the hardest state to reach. It needs sixteen collisions on one frame, each landing while a byte is actually on offer. The stimulus drives col_in from the same falling-edge process that watches the byte stream. That process counts the bytes of the current attempt and fires the collision when a chosen byte is presented. The restart is then confirmed by counting start markers, and the abandonment by the missing end marker and the written status. An odd buffer start under a random ready pattern is also exercised, so that word reuse and stalls overlap.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int LOG_W  = 3;   // width of the ring-size field
  localparam int LOG_LSB = 13; // position of that field in ring_len
  localparam int CNT_W  = 12;  // byte-count width

  typedef enum logic [3:0] {
    S_IDLE, S_RD_FLAG, S_WT_FLAG, S_RD_BASE, S_WT_BASE, S_RD_LEN, S_WT_LEN,
    S_FETCH, S_WAIT, S_SEND, S_WB_MISC, S_WB_FLAG
  } txr_state_e;
endpackage

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
  parameter int LOG_W = 3,
  localparam int IDX_W = (1 << LOG_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOG_W-1:0] ring_log,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] mask, idx_d;

  always_comb begin
    mask  = ~({IDX_W{1'b1}} << ring_log);
    idx_d = (idx + IDX_W'(1)) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= idx_d;
  end

  // the index never leaves the ring
  assert_idx_in_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx & ~mask) == '0);
endmodule

// File: rtl/txr_len_decode.sv
module txr_len_decode #(
  parameter int CNT_W = 12
) (
  input  logic [15:0]      len_word,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             zero_len
);
  logic [15:0] neg;
  always_comb begin
    neg      = 16'd0 - len_word;
    byte_cnt = neg[CNT_W-1:0];
    zero_len = (byte_cnt == '0);
  end
endmodule

// File: rtl/txr_retry_count.sv
module txr_retry_count #(
  parameter int MAX_TRIES = 16,
  localparam int CW = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic one,
  output logic more,
  output logic at_limit
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (inc && cnt_q != CW'(MAX_TRIES)) cnt_q <= cnt_q + CW'(1);
  end

  always_comb begin
    one      = (cnt_q == CW'(1));
    more     = (cnt_q > CW'(1));
    at_limit = (cnt_q == CW'(MAX_TRIES - 1));
  end

  assert_coll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_TRIES));
endmodule

// File: rtl/tx_ring_reader.sv
module tx_ring_reader
  import txr_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAX_TRIES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_demand,
  input  logic [AW-1:0] ring_base,
  input  logic [15:0]   ring_len,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_sop,
  output logic          tx_eop,
  input  logic          tx_ready,
  input  logic          col_in,
  output logic          tx_int
);
  localparam int IDX_W = (1 << LOG_W) - 1;

  txr_state_e       state_q, state_d;
  logic [7:0]       flag_q, base_hi_q;
  logic [15:0]      base_lo_q, hold_q;
  logic [CNT_W-1:0] cnt_q, pos_q, pos_d, dec_cnt;
  logic             fail_q, empty_q, dec_zero;
  logic             ld_flag, ld_lo, ld_len, ld_word, pos_en, fail_set;
  logic             coll_clr, coll_inc, coll_one, coll_more, coll_limit, ring_adv;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    desc_addr;
  logic [23:0]      baddr;
  logic             last_byte;

  txr_ring_index #(.LOG_W(LOG_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .ring_log(ring_len[LOG_LSB +: LOG_W]),
    .adv(ring_adv), .idx(idx));

  txr_len_decode #(.CNT_W(CNT_W)) u_len (
    .len_word(mem_rdata), .byte_cnt(dec_cnt), .zero_len(dec_zero));

  txr_retry_count #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(coll_clr), .inc(coll_inc),
    .one(coll_one), .more(coll_more), .at_limit(coll_limit));

  always_comb begin
    desc_addr = ring_base + AW'({idx, 2'b00});
    baddr     = {base_hi_q, base_lo_q} + {12'd0, pos_q};
    last_byte = (pos_q == cnt_q - CNT_W'(1));
    tx_data   = baddr[0] ? hold_q[7:0] : hold_q[15:8];
  end

  // next-state and output decode
  always_comb begin
    state_d = state_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = desc_addr; mem_wdata = '0;
    ld_flag = 1'b0; ld_lo = 1'b0; ld_len = 1'b0; ld_word = 1'b0;
    pos_en = 1'b0; pos_d = pos_q; fail_set = 1'b0;
    coll_clr = 1'b0; coll_inc = 1'b0; ring_adv = 1'b0;
    tx_valid = 1'b0; tx_int = 1'b0;
    unique case (state_q)
      S_IDLE:    if (tx_demand) state_d = S_RD_FLAG;
      S_RD_FLAG: begin mem_req = 1'b1; mem_addr = desc_addr + AW'(1); state_d = S_WT_FLAG; end
      S_WT_FLAG: begin
        if (mem_rdata[15]) begin ld_flag = 1'b1; state_d = S_RD_BASE; end
        else state_d = S_IDLE;
      end
      S_RD_BASE: begin mem_req = 1'b1; state_d = S_WT_BASE; end
      S_WT_BASE: begin ld_lo = 1'b1; state_d = S_RD_LEN; end
      S_RD_LEN:  begin mem_req = 1'b1; mem_addr = desc_addr + AW'(2); state_d = S_WT_LEN; end
      S_WT_LEN:  begin
        ld_len = 1'b1; coll_clr = 1'b1; pos_en = 1'b1; pos_d = '0;
        state_d = dec_zero ? S_WB_MISC : S_FETCH;
      end
      S_FETCH:   begin mem_req = 1'b1; mem_addr = baddr[AW:1]; state_d = S_WAIT; end
      S_WAIT:    begin ld_word = 1'b1; state_d = S_SEND; end
      S_SEND:    begin
        tx_valid = 1'b1;
        if (col_in) begin
          coll_inc = 1'b1;
          if (coll_limit) begin fail_set = 1'b1; state_d = S_WB_MISC; end
          else begin pos_en = 1'b1; pos_d = '0; state_d = S_FETCH; end
        end else if (tx_ready) begin
          if (last_byte) state_d = S_WB_MISC;
          else begin
            pos_en = 1'b1; pos_d = pos_q + CNT_W'(1);
            state_d = baddr[0] ? S_FETCH : S_SEND;
          end
        end
      end
      S_WB_MISC: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr + AW'(3);
        mem_wdata = {empty_q, 4'b0000, fail_q, 10'd0};
        state_d = S_WB_FLAG;
      end
      S_WB_FLAG: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr + AW'(1);
        mem_wdata = {1'b0, fail_q | empty_q, 1'b0, coll_more, coll_one, 1'b0,
                     flag_q[1:0], base_hi_q};
        tx_int = 1'b1; ring_adv = 1'b1; state_d = S_RD_FLAG;
      end
      default:   state_d = S_IDLE;
    endcase
    tx_sop = tx_valid && (pos_q == '0);
    tx_eop = tx_valid && last_byte;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; flag_q <= '0; base_hi_q <= '0; base_lo_q <= '0;
      hold_q <= '0; cnt_q <= '0; pos_q <= '0; fail_q <= 1'b0; empty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld_flag) begin flag_q <= mem_rdata[15:8]; base_hi_q <= mem_rdata[7:0]; end
      if (ld_lo)   base_lo_q <= mem_rdata;
      if (ld_word) hold_q <= mem_rdata;
      if (ld_len) begin cnt_q <= dec_cnt; empty_q <= dec_zero; end
      if (pos_en)  pos_q <= pos_d;
      if (ld_len)        fail_q <= 1'b0;
      else if (fail_set) fail_q <= 1'b1;
    end
  end

  // address/length reads only follow a flag read that returned ownership
  assert_fields_after_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RD_BASE) |-> $past(mem_rdata[15]));

  // status word lands before the flag word
  assert_misc_before_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == desc_addr + AW'(1)) |->
      $past(mem_we && mem_addr == desc_addr + AW'(3)));

  assert_int_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_int |=> !tx_int);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !col_in) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)));

  assert_no_access_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_addr != desc_addr + AW'(1)) |-> !$past(tx_int));
endmodule

// File: tb/tx_ring_reader_tb.sv
module tx_ring_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n, tx_demand, tx_ready, col_in;
  logic [15:0] ring_base, ring_len, mem_rdata, mem_wdata, mem_addr;
  logic        mem_req, mem_we, tx_valid, tx_sop, tx_eop, tx_int;
  logic [7:0]  tx_data;

  always #5 clk = ~clk;

  tx_ring_reader u_dut (
    .clk(clk), .rst_n(rst_n), .tx_demand(tx_demand), .ring_base(ring_base),
    .ring_len(ring_len), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_ready(tx_ready),
    .col_in(col_in), .tx_int(tx_int));

  int checks = 0, fails = 0;
  logic [15:0] mem [0:4095];
  logic [11:0] wr_log [0:255];
  int wr_n = 0, rd_n = 0;

  // shared memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[11:0]] = mem_wdata;
        wr_log[wr_n[7:0]] = mem_addr[11:0];
        wr_n = wr_n + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:0]];
        rd_n = rd_n + 1;
      end
    end
  end

  // byte sink and collision source
  logic [7:0] fr [0:255];
  int flen = 0, sop_cnt = 0, eop_cnt = 0, byte_cnt = 0, int_cnt = 0, stall_err = 0;
  int col_target = 0, col_done = 0, col_at = 0, att = 0;
  bit ready_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  bit prev_stall = 0;
  logic [7:0] prev_data;

  always @(negedge clk) begin
    if (prev_stall && !(tx_valid && tx_data == prev_data)) stall_err = stall_err + 1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = ready_mode ? lfsr[0] : 1'b1;
    col_in = 1'b0;
    if (tx_int) int_cnt = int_cnt + 1;
    if (tx_valid && col_done < col_target && att == col_at) begin
      col_in = 1'b1; col_done = col_done + 1; att = 0;
    end else if (tx_valid && tx_ready) begin
      if (tx_sop) begin flen = 0; att = 0; sop_cnt = sop_cnt + 1; end
      fr[flen[7:0]] = tx_data; flen = flen + 1; att = att + 1;
      byte_cnt = byte_cnt + 1;
      if (tx_eop) eop_cnt = eop_cnt + 1;
    end
    prev_stall = tx_valid && !tx_ready && !col_in;
    prev_data  = tx_data;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] daddr(input int idx);
    return 12'h100 + 12'(idx * 4);
  endfunction

  task automatic put_byte(input int ba, input logic [7:0] v);
    if (ba[0]) mem[ba[12:1]][7:0] = v; else mem[ba[12:1]][15:8] = v;
  endtask

  task automatic set_desc(input int idx, input int ba, input int cnt,
                          input logic [7:0] flag, input logic [7:0] seed);
    logic [15:0] neg;
    neg = 16'd0 - 16'(cnt);
    mem[daddr(idx)]     = ba[15:0];
    mem[daddr(idx) + 2] = neg | 16'hF000;
    mem[daddr(idx) + 3] = 16'h0000;
    for (int k = 0; k < cnt; k++) put_byte(ba + k, seed + 8'(k * 3));
    mem[daddr(idx) + 1] = {flag, 8'h00};  // ownership written last
  endtask

  task automatic demand();
    @(negedge clk); tx_demand = 1'b1;
    @(negedge clk); tx_demand = 1'b0;
  endtask

  task automatic wait_int(input int n);
    int t = 0;
    while (int_cnt < n && t < 20000) begin @(negedge clk); t++; end
    if (int_cnt < n) chk("completion timeout", int_cnt, n);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int cnt, input logic [7:0] seed);
    int bad = 0;
    chk(req, flen, cnt);
    for (int k = 0; k < cnt; k++) if (fr[k] != seed + 8'(k * 3)) bad++;
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_demand = 1'b0;
    ring_base = 16'h0100; ring_len = 16'h4000;  // 4 entries
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 tx_int", int'(tx_int), 0);
    repeat (10) @(negedge clk);
    chk("R1 no access without demand", rd_n + wr_n, 0);
  endtask

  task automatic t_basic();
    int rd0;
    set_desc(0, 16'h1000, 60, 8'h83, 8'h11);
    demand(); wait_int(1);
    check_frame("R4 R5 basic frame", 60, 8'h11);
    chk("R6 one sop", sop_cnt, 1);
    chk("R6 one eop", eop_cnt, 1);
    chk("R7 misc first", int'(wr_log[0]), int'(daddr(0) + 3));
    chk("R7 flag second", int'(wr_log[1]), int'(daddr(0) + 1));
    chk("R7 flag word", int'(mem[daddr(0) + 1]), 16'h0300);
    chk("R7 misc word", int'(mem[daddr(0) + 3]), 0);
    chk("R7 single int", int_cnt, 1);
    rd0 = rd_n;
    set_desc(1, 16'h1201, 61, 8'h83, 8'h40);  // handed over while idle
    repeat (40) @(negedge clk);
    chk("R2 idle ignores new owned entry", rd_n - rd0, 0);
    chk("R2 no int while idle", int_cnt, 1);
  endtask

  task automatic t_odd_stall();
    ready_mode = 1;
    demand(); wait_int(2);
    ready_mode = 0;
    check_frame("R5 odd start", 61, 8'h40);
    chk("R6 stall stability", stall_err, 0);
    chk("R7 flag idx1", int'(mem[daddr(1) + 1]), 16'h0300);
  endtask

  task automatic t_coll(input int idx, input int n, input int at, input int nint,
                        input logic [15:0] exp_flag, input logic [7:0] seed);
    int s0 = sop_cnt;
    set_desc(idx, 16'h1400 + idx * 16'h200, 64, 8'h83, seed);
    col_at = at; col_target = col_done + n;
    demand(); wait_int(nint);
    check_frame("R8 retried frame", 64, seed);
    chk("R8 restarts", sop_cnt - s0, n + 1);
    chk("R8 flag", int'(mem[daddr(idx) + 1]), int'(exp_flag));
    chk("R8 misc", int'(mem[daddr(idx) + 3]), 0);
  endtask

  task automatic t_fail();
    int e0 = eop_cnt;
    mem[16'h110] = 16'h1234; mem[16'h111] = 16'h8300;  // just past ring end
    set_desc(0, 16'h1c00, 60, 8'h83, 8'h22);
    col_at = 5; col_target = col_done + 16;
    demand(); wait_int(5);
    chk("R9 no eop", eop_cnt - e0, 0);
    chk("R9 misc retry bit", int'(mem[daddr(0) + 3]), 16'h0400);
    chk("R9 flag error", int'(mem[daddr(0) + 1]), 16'h5300);
    chk("R10 wrap past end untouched", int'(mem[16'h111]), 16'h8300);
    chk("R9 collisions used", col_done, col_target);
  endtask

  task automatic t_zero();
    int b0 = byte_cnt;
    set_desc(1, 16'h1e00, 0, 8'h83, 8'h00);
    demand(); wait_int(6);
    chk("R11 no bytes", byte_cnt - b0, 0);
    chk("R11 misc", int'(mem[daddr(1) + 3]), 16'h8000);
    chk("R11 flag", int'(mem[daddr(1) + 1]), 16'h4300);
  endtask

  task automatic t_multi();
    set_desc(2, 16'h1400, 60, 8'h83, 8'h31);
    set_desc(3, 16'h1600, 62, 8'h83, 8'h52);
    demand(); wait_int(8);
    chk("R2 two in one scan", int_cnt, 8);
    check_frame("R2 second frame", 62, 8'h52);
    chk("R2 stop at host entry", int'(mem[daddr(0) + 1]), 16'h5300);
  endtask

  initial begin
    tx_ready = 1'b1; col_in = 1'b0;
    t_reset();
    t_basic();
    t_odd_stall();
    t_coll(2, 1, 10, 3, 16'h0B00, 8'h70);
    t_coll(3, 3, 7, 4, 16'h1300, 8'h90);
    t_fail();
    t_zero();
    t_multi();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule